// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management register file of a single Ethernet PHY as seen from the host. The host reaches it through one 32-bit management frame register. Each write strobe on that register starts one management operation. The operation either reads or writes one 16-bit PHY register, and it finishes in a single cycle. A read replaces the whole frame register with the zero-extended result. A write leaves the frame register holding the word that was written. In both cases a one-cycle completion pulse follows, and the controller uses that pulse as its management-done event.

Inside, the block holds five registers: control, status, advertisement, interrupt source and interrupt mask. It also answers four fixed registers with identity and partner-ability constants. Writes are masked per register. Autonegotiation completes at once. The interrupt source register clears when it is read.

A link-level input is sampled every cycle. Its effects are applied once after reset and then on every change of level. When the link is up, the link and autonegotiation-complete status bits are set and the up events are raised. When the link goes down, those status bits are cleared and the down event is raised. Serial MDIO pin timing and real negotiation are not part of this block.

Top module: `mgmt_phy_regs`

## Requirements
- R1: The operation word is decoded in three fields. Bit 28 selects write (1) or read (0). Bits 26:18 give the register number. Bits 15:0 hold the write data. Every strobe produces `mgmt_done` high for exactly the following cycle, and `mgmt_done` is low in every other cycle.
- R2: After a read, `mgmt_frame` equals the 16-bit result with bits 31:16 zero. After a write, `mgmt_frame` equals the written word. Out of reset, `mgmt_frame` is 0.
- R3: After reset, the registers hold control 0x3000, advertisement 0x01E1, interrupt mask 0 and interrupt source 0, and status holds 0x7809. The current link level is then applied once. With the link up, status therefore reads 0x782D and interrupt source reads 0x00C0.
- R4: Registers 2, 3, 5 and 6 read 0x0007, 0xC0D1, 0x0F71 and 0x0001.
- R5: A write to register 0 with bit 15 set restores every R3 reset value and re-applies the current link level. Any other write to register 0 stores the value AND 0x7980. If bit 12 of the written value is set, the write also sets status bit 5.
- R6: A write to register 4 stores (value AND 0x2D7F) OR 0x0080. A write to register 30 stores the low 8 bits of the value.
- R7: A read of register 29 returns the interrupt source and then clears it to 0.
- R8: When the link level changes to up, status bits 5 and 2 are set and interrupt source bits 7 and 6 are set. When it changes to down, status bits 5 and 2 are cleared and interrupt source bit 4 is set. While the level is steady, none of these bits is touched.
- R9: The following registers read as 0 and ignore writes: 17, 18, 27 and 31, every unmapped number up to 31, and every number from 32 to 511. Numbers from 32 upward do not alias onto registers 0 to 31. Writes to registers 1, 2, 3, 5, 6 and 29 have no effect.
- R10: If an operation and a link change fall in the same cycle, the operation takes effect first and the link effects are applied on top of its result. A read of register 29 in that cycle returns the value held before the change, and the new link event stays pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | One-cycle strobe: the host writes the frame register |
| frame_wdata | input | 32 | Operation word written by the host |
| link_up | input | 1 | Current link level, 1 = up |
| mgmt_done | output | 1 | Completion pulse, one cycle after each strobe |
| mgmt_frame | output | 32 | Frame register contents as read by the host |

## Verification
The bench builds the block with its default parameters: a 32-bit frame word, a 9-bit register field at bit 18 and the write flag at bit 28. Because the register field is wider than the five bits the PHY decodes, numbers from 32 to 511 can be issued. The bench uses this to show that such numbers read zero and do not alias onto the low registers. It also drives link changes in the same cycle as a clear-on-read access, so the update order is observable at the ports.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    localparam int PHY_DW    = 16;
    localparam int REG_IDX_W = 5;

    // register numbers decoded by the PHY
    localparam logic [REG_IDX_W-1:0] RA_CTRL    = 5'd0;
    localparam logic [REG_IDX_W-1:0] RA_STAT    = 5'd1;
    localparam logic [REG_IDX_W-1:0] RA_ID_HI   = 5'd2;
    localparam logic [REG_IDX_W-1:0] RA_ID_LO   = 5'd3;
    localparam logic [REG_IDX_W-1:0] RA_ADV     = 5'd4;
    localparam logic [REG_IDX_W-1:0] RA_PARTNER = 5'd5;
    localparam logic [REG_IDX_W-1:0] RA_EXPAN   = 5'd6;
    localparam logic [REG_IDX_W-1:0] RA_ISRC    = 5'd29;
    localparam logic [REG_IDX_W-1:0] RA_IMSK    = 5'd30;

    // fixed read values
    localparam logic [PHY_DW-1:0] ID_HI_VAL   = 16'h0007;
    localparam logic [PHY_DW-1:0] ID_LO_VAL   = 16'hC0D1;
    localparam logic [PHY_DW-1:0] PARTNER_VAL = 16'h0F71;
    localparam logic [PHY_DW-1:0] EXPAN_VAL   = 16'h0001;

    // write masks
    localparam logic [PHY_DW-1:0] CTRL_WMASK = 16'h7980;
    localparam logic [PHY_DW-1:0] ADV_WMASK  = 16'h2D7F;
    localparam logic [PHY_DW-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [PHY_DW-1:0] IMSK_WMASK = 16'h00FF;
    localparam int CTRL_RST_BIT  = 15;
    localparam int CTRL_ANEG_BIT = 12;

    // link side effects
    localparam logic [PHY_DW-1:0] STAT_LINK_BITS = 16'h0024;
    localparam logic [PHY_DW-1:0] STAT_ANEG_DONE = 16'h0020;
    localparam logic [PHY_DW-1:0] ISRC_UP_BITS   = 16'h00C0;
    localparam logic [PHY_DW-1:0] ISRC_DOWN_BITS = 16'h0010;

    typedef struct packed {
        logic [PHY_DW-1:0] ctrl;
        logic [PHY_DW-1:0] stat;
        logic [PHY_DW-1:0] adv;
        logic [PHY_DW-1:0] isrc;
        logic [PHY_DW-1:0] imsk;
    } phy_state_t;

    localparam phy_state_t PHY_RESET_STATE = '{
        ctrl: 16'h3000,
        stat: 16'h7809,
        adv:  16'h01E1,
        isrc: 16'h0000,
        imsk: 16'h0000
    };

    typedef struct packed {
        logic                 valid;
        logic                 is_wr;
        logic                 in_range;
        logic [REG_IDX_W-1:0] idx;
        logic [PHY_DW-1:0]    wdata;
    } mgmt_op_t;

endpackage

// File: rtl/mgmt_phy_link.sv
module mgmt_phy_link (
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    output logic link_evt
);

    typedef struct packed {
        logic primed;
        logic lvl;
    } link_state_t;

    link_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.lvl    = link_in;
        // first cycle after reset, or any change of level
        link_evt    = !st_q.primed || (link_in != st_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mgmt_phy_decode.sv
module mgmt_phy_decode
    import mgmt_phy_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int ADDR_W   = 9,
    parameter int ADDR_LSB = 18,
    parameter int WR_BIT   = 28
) (
    input  logic               strobe,
    input  logic [FRAME_W-1:0] word,
    output mgmt_op_t           op
);

    localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

    logic upper_zero;
    logic unused_word;

    assign unused_word = ^word;

    generate
        if (ADDR_W > REG_IDX_W) begin : g_wide_addr
            assign upper_zero = (word[ADDR_MSB:ADDR_LSB+REG_IDX_W] == '0);
        end else begin : g_narrow_addr
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        op          = '0;
        op.valid    = strobe;
        op.is_wr    = word[WR_BIT];
        op.in_range = upper_zero;
        op.idx      = word[ADDR_LSB +: REG_IDX_W];
        op.wdata    = word[PHY_DW-1:0];
    end

endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
    import mgmt_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mgmt_op_t          op,
    input  logic              link_evt,
    input  logic              link_lvl,
    output logic [PHY_DW-1:0] rdata
);

    phy_state_t state_d, state_q;
    logic       apply_link;

    // read mux works on the value held before this cycle's update
    always_comb begin
        rdata = '0;
        if (op.in_range) begin
            case (op.idx)
                RA_CTRL:    rdata = state_q.ctrl;
                RA_STAT:    rdata = state_q.stat;
                RA_ID_HI:   rdata = ID_HI_VAL;
                RA_ID_LO:   rdata = ID_LO_VAL;
                RA_ADV:     rdata = state_q.adv;
                RA_PARTNER: rdata = PARTNER_VAL;
                RA_EXPAN:   rdata = EXPAN_VAL;
                RA_ISRC:    rdata = state_q.isrc;
                RA_IMSK:    rdata = state_q.imsk;
                default:    rdata = '0;
            endcase
        end
    end

    always_comb begin
        state_d    = state_q;
        apply_link = link_evt;

        // management operation first
        if (op.valid && op.in_range) begin
            if (op.is_wr) begin
                case (op.idx)
                    RA_CTRL: begin
                        if (op.wdata[CTRL_RST_BIT]) begin
                            state_d    = PHY_RESET_STATE;
                            apply_link = 1'b1;
                        end else begin
                            state_d.ctrl = op.wdata & CTRL_WMASK;
                            if (op.wdata[CTRL_ANEG_BIT]) begin
                                state_d.stat = state_d.stat | STAT_ANEG_DONE;
                            end
                        end
                    end
                    RA_ADV:  state_d.adv  = (op.wdata & ADV_WMASK) | ADV_FORCE;
                    RA_IMSK: state_d.imsk = op.wdata & IMSK_WMASK;
                    default: ;
                endcase
            end else if (op.idx == RA_ISRC) begin
                state_d.isrc = '0;
            end
        end

        // link effects on top of the operation's result
        if (apply_link) begin
            if (link_lvl) begin
                state_d.stat = state_d.stat | STAT_LINK_BITS;
                state_d.isrc = state_d.isrc | ISRC_UP_BITS;
            end else begin
                state_d.stat = state_d.stat & ~STAT_LINK_BITS;
                state_d.isrc = state_d.isrc | ISRC_DOWN_BITS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PHY_RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int ADDR_W   = 9,
    parameter int ADDR_LSB = 18,
    parameter int WR_BIT   = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               link_up,
    output logic               mgmt_done,
    output logic [FRAME_W-1:0] mgmt_frame
);

    localparam int PAD_W = FRAME_W - PHY_DW;

    typedef struct packed {
        logic               done;
        logic [FRAME_W-1:0] frame;
    } frame_state_t;

    mgmt_op_t          op;
    logic              link_evt;
    logic [PHY_DW-1:0] rd_val;
    frame_state_t      fr_d, fr_q;

    mgmt_phy_decode #(
        .FRAME_W  (FRAME_W),
        .ADDR_W   (ADDR_W),
        .ADDR_LSB (ADDR_LSB),
        .WR_BIT   (WR_BIT)
    ) u_dec (
        .strobe (frame_wr),
        .word   (frame_wdata),
        .op     (op)
    );

    mgmt_phy_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_in  (link_up),
        .link_evt (link_evt)
    );

    mgmt_phy_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .link_evt (link_evt),
        .link_lvl (link_up),
        .rdata    (rd_val)
    );

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = op.valid;
        if (op.valid) begin
            fr_d.frame = op.is_wr ? frame_wdata : {{PAD_W{1'b0}}, rd_val};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign mgmt_done  = fr_q.done;
    assign mgmt_frame = fr_q.frame;

endmodule

// File: rtl/mgmt_phy_regs_chk.sv
module mgmt_phy_regs_chk #(
    parameter int FRAME_W  = 32,
    parameter int ADDR_W   = 9,
    parameter int ADDR_LSB = 18,
    parameter int WR_BIT   = 28
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_wr,
    input logic [FRAME_W-1:0] frame_wdata,
    input logic               link_up,
    input logic               mgmt_done,
    input logic [FRAME_W-1:0] mgmt_frame,
    input logic [15:0]        phy_stat
);

    logic [ADDR_W-1:0] reg_num;
    logic              is_rd;
    assign reg_num = frame_wdata[ADDR_LSB +: ADDR_W];
    assign is_rd   = !frame_wdata[WR_BIT];

    assert_done_after_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> mgmt_done);

    assert_no_stray_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> !mgmt_done);

    assert_write_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !is_rd) |=> (mgmt_frame == $past(frame_wdata)));

    assert_read_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && is_rd) |=> (mgmt_frame[FRAME_W-1:16] == '0));

    assert_id_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && is_rd && reg_num == ADDR_W'(2)) |=> (mgmt_frame == FRAME_W'(16'h0007)));

    assert_high_num_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && is_rd && reg_num >= ADDR_W'(32)) |=> (mgmt_frame == '0));

    assert_link_up_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> phy_stat[2]);

    assert_link_down_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !phy_stat[2]);

endmodule

bind mgmt_phy_regs mgmt_phy_regs_chk #(
    .FRAME_W  (FRAME_W),
    .ADDR_W   (ADDR_W),
    .ADDR_LSB (ADDR_LSB),
    .WR_BIT   (WR_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_wr    (frame_wr),
    .frame_wdata (frame_wdata),
    .link_up     (link_up),
    .mgmt_done   (mgmt_done),
    .mgmt_frame  (mgmt_frame),
    .phy_stat    (u_rf.state_q.stat)
);

// File: tb/mgmt_phy_regs_test.sv
`timescale 1ns/1ps
module mgmt_phy_regs_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_wr;
    logic [31:0] frame_wdata;
    logic        link_up;
    logic        mgmt_done;
    logic [31:0] mgmt_frame;
    logic        link_lvl;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    mgmt_phy_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .link_up     (link_up),
        .mgmt_done   (mgmt_done),
        .mgmt_frame  (mgmt_frame)
    );

    function automatic logic [31:0] mk_word(bit wr, int num, logic [15:0] d);
        return (wr ? 32'h1000_0000 : 32'h0) | ((32'(num) & 32'h1FF) << 18) | {16'h0, d};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: issue one operation and queue what the frame register must show
    task automatic op(bit wr, int num, logic [15:0] d, logic [31:0] exp, string tag);
        @(negedge clk);
        frame_wr    = 1'b1;
        frame_wdata = mk_word(wr, num, d);
        link_up     = link_lvl;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        frame_wr    = 1'b0;
        frame_wdata = '0;
    endtask

    task automatic rd(int num, logic [15:0] exp, string tag);
        op(1'b0, num, 16'h0, {16'h0, exp}, tag);
    endtask

    task automatic wr(int num, logic [15:0] d, string tag);
        op(1'b1, num, d, mk_word(1'b1, num, d), tag);
    endtask

    task automatic set_link(bit v);
        @(negedge clk);
        link_lvl = v;
        link_up  = v;
        @(negedge clk);
    endtask

    // monitor: pop and compare on every completion pulse
    always @(negedge clk) begin : monitor
        logic [31:0] e;
        string       t;
        if (rst_n && mgmt_done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1 unexpected done actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, mgmt_frame, e);
            end
        end
    end

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n       = 1'b0;
        frame_wr    = 1'b0;
        frame_wdata = '0;
        link_lvl    = 1'b1;
        link_up     = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done in reset", {31'h0, mgmt_done}, 32'h0);
        check("R2 frame reset", mgmt_frame, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle done", {31'h0, mgmt_done}, 32'h0);

        // R3 reset values with the link applied once
        rd(1,  16'h782D, "R3 status");
        rd(0,  16'h3000, "R3 control");
        rd(4,  16'h01E1, "R3 adv");
        rd(30, 16'h0000, "R3 imask");
        rd(29, 16'h00C0, "R3 isrc after link");
        rd(29, 16'h0000, "R7 isrc cleared");

        // R4 constants
        rd(2, 16'h0007, "R4 reg2");
        rd(3, 16'hC0D1, "R4 reg3");
        rd(5, 16'h0F71, "R4 reg5");
        rd(6, 16'h0001, "R4 reg6");

        // R2 / R6 masked writes
        wr(4, 16'hFFFF, "R2 write echo");
        rd(4, 16'h2DFF, "R6 adv all ones");
        wr(4, 16'h0000, "R2 write echo");
        rd(4, 16'h0080, "R6 adv forced bit");
        wr(30, 16'h1234, "R2 write echo");
        rd(30, 16'h0034, "R6 imask low byte");

        // R8 link down, R5 control writes
        set_link(1'b0);
        rd(29, 16'h0010, "R8 down event");
        rd(1,  16'h7809, "R8 status down");
        wr(0,  16'h1000, "R2 write echo");
        rd(0,  16'h1000, "R5 control masked");
        rd(1,  16'h7829, "R5 aneg done bit");
        wr(0,  16'h7FFF, "R2 write echo");
        rd(0,  16'h7980, "R5 control mask");

        // R8 steady level raises nothing
        repeat (5) @(negedge clk);
        rd(29, 16'h0000, "R8 steady level");

        // R9 reserved, unmapped, high numbers, read-only registers
        wr(17, 16'hFFFF, "R2 write echo");
        rd(17, 16'h0000, "R9 reg17");
        rd(31, 16'h0000, "R9 reg31");
        rd(7,  16'h0000, "R9 unmapped reg7");
        wr(300, 16'hFFFF, "R2 write echo");
        rd(300, 16'h0000, "R9 reg300");
        wr(62, 16'h00FF, "R2 write echo");
        rd(30, 16'h0034, "R9 no alias from 62");
        wr(1,  16'h0000, "R2 write echo");
        rd(1,  16'h7829, "R9 status write ignored");
        wr(2,  16'h1111, "R2 write echo");
        rd(2,  16'h0007, "R9 reg2 write ignored");

        // R5 PHY reset with link up
        set_link(1'b1);
        wr(0,  16'h8000, "R2 write echo");
        rd(0,  16'h3000, "R5 reset control");
        rd(4,  16'h01E1, "R5 reset adv");
        rd(30, 16'h0000, "R5 reset imask");
        rd(1,  16'h782D, "R5 reset status link up");
        rd(29, 16'h00C0, "R5 reset isrc link up");
        rd(29, 16'h0000, "R7 isrc cleared again");

        // R10 link change in the same cycle as the clear-on-read
        link_lvl = 1'b0;
        rd(29, 16'h0000, "R10 read sees old value");
        rd(29, 16'h0010, "R10 event survives clear");
        rd(1,  16'h7809, "R10 status down");

        // R5 PHY reset with link down
        wr(0,  16'h8000, "R2 write echo");
        rd(29, 16'h0010, "R5 reset re-applies link down");
        rd(1,  16'h7809, "R5 reset status link down");

        repeat (4) @(negedge clk);
        check("R1 all operations completed", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule